// File: doc/BRIEF.md
# Hypervisor-aware trap entry and return sequencer

This block keeps the privilege state of a hart that supports virtualization. It holds the current mode (M, S or U), the virtualization flag V, and three separate banks of trap registers: one for machine mode, one for the hypervisor-level supervisor (HS), and one for the virtual supervisor (VS). A trap request carries a cause, an interrupt flag, the faulting PC, two trap values, a transformed instruction word and a guest-address flag. Each request is sent to one of three destinations, and only the bank that belongs to that destination is written.

MRET and SRET requests restore the mode and V from the saved state of the bank they use. Each trap or return produces a one-cycle redirect carrying the target PC. On a trap the target is the vector base of the destination. On a return it is the saved exception PC. The delegation masks and vector bases are plain inputs. Interrupt arbitration, instruction legality and the pipeline sit outside this block.

Top module: `trap_seq`

## Requirements
- R1: After reset the mode is M (mode code 3; S is 1 and U is 0) and V is 0. The saved machine previous-mode field holds 1 and the saved machine previous-V bit holds 1 (parameters). Every other status bit and register is 0, and redir_vld is 0.
- R2: A trap goes to M if the current mode is M, or if the machine delegation bit indexed by the cause is clear (mideleg for interrupts, medeleg for exceptions). Otherwise it goes to VS if V is 1 and the hypervisor delegation bit for the cause is set (hideleg or hedeleg). In every other case it goes to HS.
- R3: A trap into M gives mode 3 and V 0. It saves the old V in m_mpv and the old mode in m_mpp, copies trap_gva into m_gva, copies m_mie into m_mpie and clears m_mie. It loads mepc, mcause, mtval, mtval2 and mtinst from the request.
- R4: A trap into HS gives mode 1 and V 0. It saves the old V in h_spv, the old mode's S bit in s_spp and trap_gva in h_gva. It copies s_sie into s_spie and clears s_sie. It loads sepc, scause and stval, and loads htval from the second trap value and htinst from the instruction word.
- R5: A trap into HS changes h_spvp only when the old V is 1. In that case h_spvp takes the old mode's S bit; otherwise it keeps its value.
- R6: A trap into VS gives mode 1 and keeps V at 1. It sets vs_spp to 1 when the origin is VS and to 0 when the origin is VU. It copies vs_sie into vs_spie, clears vs_sie, and loads vsepc, vscause and vstval. All HS and M registers and status bits stay unchanged.
- R7: A cause register holds the interrupt flag in bit XLEN-1 and the cause code in its low CW bits, with zeros in between. Ecall-from-VS (code 10) and ecall-from-HS (code 9) are delegated independently, each through its own bit.
- R8: MRET, accepted only in M, sets the mode to m_mpp and V to m_mpv, except that m_mpp = 3 forces V to 0. It then clears m_mpp and m_mpv, sets m_mie from m_mpie and sets m_mpie to 1.
- R9: SRET with V = 0, accepted in S or M, sets the mode to s_spp and V to h_spv. It then clears h_spv and s_spp, sets s_sie from s_spie and sets s_spie to 1.
- R10: SRET with V = 1, accepted in VS, sets the mode to vs_spp and keeps V at 1. It clears vs_spp, sets vs_sie from vs_spie and sets vs_spie to 1. HS and M state stay unchanged.
- R11: With the double-trap option on (default), a trap into VS sets vs_sdt. An SRET executed in VS clears vs_sdt, and so does an SRET at V = 0 that enters VU.
- R12: The cycle after an accepted trap or return, redir_vld is 1 and redir_pc holds the target: the destination's vector base for a trap, or mepc, sepc or vsepc for a return. In every other cycle redir_vld is 0.
- R13: MRET below M and SRET in U (with either V) are ignored, leaving mode, V and all registers unchanged. A trap request wins over an xRET request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trap_req | input | 1 | Take a trap this cycle |
| trap_irq | input | 1 | The trap is an interrupt |
| trap_cause | input | CW | Cause code |
| trap_pc | input | XLEN | PC of the trapping instruction |
| trap_tval | input | XLEN | First trap value |
| trap_tval2 | input | XLEN | Second trap value (guest physical address) |
| trap_tinst | input | XLEN | Transformed instruction word |
| trap_gva | input | 1 | Trap value is a guest virtual address |
| mret_req | input | 1 | MRET request |
| sret_req | input | 1 | SRET request |
| medeleg | input | 2**CW | Machine exception delegation mask |
| mideleg | input | 2**CW | Machine interrupt delegation mask |
| hedeleg | input | 2**CW | Hypervisor exception delegation mask |
| hideleg | input | 2**CW | Hypervisor interrupt delegation mask |
| m_tvec | input | XLEN | M trap vector base |
| s_tvec | input | XLEN | HS trap vector base |
| vs_tvec | input | XLEN | VS trap vector base |
| priv | output | 2 | Current mode |
| virt | output | 1 | Current V |
| redir_vld | output | 1 | Redirect valid |
| redir_pc | output | XLEN | Redirect target |
| m_mie | output | 1 | M interrupt enable |
| m_mpie | output | 1 | M previous interrupt enable |
| m_mpp | output | 2 | M previous mode |
| m_mpv | output | 1 | M previous V |
| m_gva | output | 1 | M guest-address flag |
| mepc | output | XLEN | M exception PC |
| mcause | output | XLEN | M cause |
| mtval | output | XLEN | M trap value |
| mtval2 | output | XLEN | M second trap value |
| mtinst | output | XLEN | M trap instruction |
| s_sie | output | 1 | HS interrupt enable |
| s_spie | output | 1 | HS previous interrupt enable |
| s_spp | output | 1 | HS previous mode |
| h_spv | output | 1 | HS previous V |
| h_spvp | output | 1 | Previous mode of the last guest trapped into HS |
| h_gva | output | 1 | HS guest-address flag |
| sepc | output | XLEN | HS exception PC |
| scause | output | XLEN | HS cause |
| stval | output | XLEN | HS trap value |
| htval | output | XLEN | HS second trap value |
| htinst | output | XLEN | HS trap instruction |
| vs_sie | output | 1 | VS interrupt enable |
| vs_spie | output | 1 | VS previous interrupt enable |
| vs_spp | output | 1 | VS previous mode |
| vs_sdt | output | 1 | VS double-trap flag |
| vsepc | output | XLEN | VS exception PC |
| vscause | output | XLEN | VS cause |
| vstval | output | XLEN | VS trap value |

## Verification
The embedded assertions are checked on every cycle. They cover: a VS-bound trap leaves every HS register and HS status bit untouched; a trap taken in M stays in M; MRET with saved mode 3 lands in M with V cleared; MRET moves MPIE into MIE; h_spvp holds across HS traps taken with V = 0; vs_sdt clears on the returns that must clear it; and redir_vld stays low when no request is present. Only the bench scenarios can show the full routing. These include walking through VS, VU, HS, U and M in sequence, independent delegation of codes 9 and 10, exact cause-word formatting, the saved previous-mode bits for each origin, and the precedence of a trap over a simultaneous MRET.

// File: rtl/trap_pkg.sv
package trap_pkg;

  localparam logic [1:0] PRV_U = 2'd0;
  localparam logic [1:0] PRV_S = 2'd1;
  localparam logic [1:0] PRV_M = 2'd3;

  typedef enum logic [1:0] {
    DST_M  = 2'd0,
    DST_HS = 2'd1,
    DST_VS = 2'd2
  } trap_dst_e;

  // Destination choice from the current mode and the two delegation bits
  // already selected for this cause.
  function automatic trap_dst_e pick_dst(input logic [1:0] prv, input logic v,
                                         input logic mdel, input logic hdel);
    if (prv == PRV_M || !mdel) return DST_M;
    if (v && hdel)             return DST_VS;
    return DST_HS;
  endfunction

endpackage

// File: rtl/trap_route.sv
module trap_route
  import trap_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic                 irq,
  input  logic [CW-1:0]        cause,
  input  logic [1:0]           prv,
  input  logic                 virt,
  input  logic [(1<<CW)-1:0]   medeleg,
  input  logic [(1<<CW)-1:0]   mideleg,
  input  logic [(1<<CW)-1:0]   hedeleg,
  input  logic [(1<<CW)-1:0]   hideleg,
  output trap_dst_e            dst
);

  logic m_bit;
  logic h_bit;

  assign m_bit = irq ? mideleg[cause] : medeleg[cause];
  assign h_bit = irq ? hideleg[cause] : hedeleg[cause];
  assign dst   = pick_dst(prv, virt, m_bit, h_bit);

endmodule

// File: rtl/trap_mbank.sv
module trap_mbank #(
  parameter int         XLEN    = 32,
  parameter logic [1:0] RST_MPP = 2'd1,
  parameter logic       RST_MPV = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ent,
  input  logic            ret,
  input  logic [1:0]      old_prv,
  input  logic            old_virt,
  input  logic            gva,
  input  logic [XLEN-1:0] cause_w,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] tval,
  input  logic [XLEN-1:0] tval2,
  input  logic [XLEN-1:0] tinst,
  output logic            mie,
  output logic            mpie,
  output logic [1:0]      mpp,
  output logic            mpv,
  output logic            gva_q,
  output logic [XLEN-1:0] epc,
  output logic [XLEN-1:0] cause_q,
  output logic [XLEN-1:0] tval_q,
  output logic [XLEN-1:0] tval2_q,
  output logic [XLEN-1:0] tinst_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mie     <= 1'b0;
      mpie    <= 1'b0;
      mpp     <= RST_MPP;
      mpv     <= RST_MPV;
      gva_q   <= 1'b0;
      epc     <= '0;
      cause_q <= '0;
      tval_q  <= '0;
      tval2_q <= '0;
      tinst_q <= '0;
    end else if (ent) begin
      mpv     <= old_virt;
      mpp     <= old_prv;
      gva_q   <= gva;
      mpie    <= mie;
      mie     <= 1'b0;
      epc     <= pc;
      cause_q <= cause_w;
      tval_q  <= tval;
      tval2_q <= tval2;
      tinst_q <= tinst;
    end else if (ret) begin
      mpp  <= 2'd0;
      mpv  <= 1'b0;
      mie  <= mpie;
      mpie <= 1'b1;
    end
  end

  // R8: MRET moves the saved enable back and leaves previous fields cleared
  a_r8_mret_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !ent) |=> (mie == $past(mpie)) && mpie && (mpp == 2'd0) && !mpv);

  // R3: entry always disables machine interrupts
  a_r3_entry_mie_off: assert property (@(posedge clk) disable iff (!rst_n)
    ent |=> !mie && (mpie == $past(mie)));

endmodule

// File: rtl/trap_hsbank.sv
module trap_hsbank #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ent,
  input  logic            ret,
  input  logic            old_s,
  input  logic            old_virt,
  input  logic            gva,
  input  logic [XLEN-1:0] cause_w,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] tval,
  input  logic [XLEN-1:0] tval2,
  input  logic [XLEN-1:0] tinst,
  output logic            sie,
  output logic            spie,
  output logic            spp,
  output logic            spv,
  output logic            spvp,
  output logic            gva_q,
  output logic [XLEN-1:0] epc,
  output logic [XLEN-1:0] cause_q,
  output logic [XLEN-1:0] tval_q,
  output logic [XLEN-1:0] htval,
  output logic [XLEN-1:0] htinst
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sie     <= 1'b0;
      spie    <= 1'b0;
      spp     <= 1'b0;
      spv     <= 1'b0;
      spvp    <= 1'b0;
      gva_q   <= 1'b0;
      epc     <= '0;
      cause_q <= '0;
      tval_q  <= '0;
      htval   <= '0;
      htinst  <= '0;
    end else if (ent) begin
      spv     <= old_virt;
      if (old_virt) spvp <= old_s;
      gva_q   <= gva;
      spp     <= old_s;
      spie    <= sie;
      sie     <= 1'b0;
      epc     <= pc;
      cause_q <= cause_w;
      tval_q  <= tval;
      htval   <= tval2;
      htinst  <= tinst;
    end else if (ret) begin
      spv  <= 1'b0;
      spp  <= 1'b0;
      sie  <= spie;
      spie <= 1'b1;
    end
  end

  // R5: a trap taken from a non-virtual mode leaves the guest previous-mode bit
  a_r5_spvp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ent && !old_virt) |=> $stable(spvp));

  // R9: SRET at V=0 clears the saved V and re-arms SPIE
  a_r9_sret_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !ent) |=> !spv && !spp && spie);

endmodule

// File: rtl/trap_vsbank.sv
module trap_vsbank #(
  parameter int XLEN     = 32,
  parameter bit DBL_TRAP = 1'b1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ent,
  input  logic            ret,
  input  logic            clr,
  input  logic            old_s,
  input  logic [XLEN-1:0] cause_w,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] tval,
  output logic            sie,
  output logic            spie,
  output logic            spp,
  output logic            sdt,
  output logic [XLEN-1:0] epc,
  output logic [XLEN-1:0] cause_q,
  output logic [XLEN-1:0] tval_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sie     <= 1'b0;
      spie    <= 1'b0;
      spp     <= 1'b0;
      epc     <= '0;
      cause_q <= '0;
      tval_q  <= '0;
    end else if (ent) begin
      spp     <= old_s;
      spie    <= sie;
      sie     <= 1'b0;
      epc     <= pc;
      cause_q <= cause_w;
      tval_q  <= tval;
    end else if (ret) begin
      spp  <= 1'b0;
      sie  <= spie;
      spie <= 1'b1;
    end
  end

  generate
    if (DBL_TRAP) begin : g_sdt
      logic sdt_q;
      always_ff @(posedge clk) begin
        if (!rst_n)          sdt_q <= 1'b0;
        else if (ent)        sdt_q <= 1'b1;
        else if (ret || clr) sdt_q <= 1'b0;
      end
      assign sdt = sdt_q;

      // R11: the returns that must clear the double-trap flag do so
      a_r11_sdt_clear: assert property (@(posedge clk) disable iff (!rst_n)
        ((ret || clr) && !ent) |=> !sdt);
    end else begin : g_no_sdt
      assign sdt = 1'b0;
    end
  endgenerate

  // R10: a VS return re-arms SPIE and clears the saved mode
  a_r10_vs_ret: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !ent) |=> spie && !spp && (sie == $past(spie)));

endmodule

// File: rtl/trap_seq.sv
module trap_seq
  import trap_pkg::*;
#(
  parameter int         XLEN     = 32,
  parameter int         CW       = 5,
  parameter logic [1:0] RST_MPP  = 2'd1,
  parameter logic       RST_MPV  = 1'b1,
  parameter bit         DBL_TRAP = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                trap_req,
  input  logic                trap_irq,
  input  logic [CW-1:0]       trap_cause,
  input  logic [XLEN-1:0]     trap_pc,
  input  logic [XLEN-1:0]     trap_tval,
  input  logic [XLEN-1:0]     trap_tval2,
  input  logic [XLEN-1:0]     trap_tinst,
  input  logic                trap_gva,
  input  logic                mret_req,
  input  logic                sret_req,
  input  logic [(1<<CW)-1:0]  medeleg,
  input  logic [(1<<CW)-1:0]  mideleg,
  input  logic [(1<<CW)-1:0]  hedeleg,
  input  logic [(1<<CW)-1:0]  hideleg,
  input  logic [XLEN-1:0]     m_tvec,
  input  logic [XLEN-1:0]     s_tvec,
  input  logic [XLEN-1:0]     vs_tvec,
  output logic [1:0]          priv,
  output logic                virt,
  output logic                redir_vld,
  output logic [XLEN-1:0]     redir_pc,
  output logic                m_mie,
  output logic                m_mpie,
  output logic [1:0]          m_mpp,
  output logic                m_mpv,
  output logic                m_gva,
  output logic [XLEN-1:0]     mepc,
  output logic [XLEN-1:0]     mcause,
  output logic [XLEN-1:0]     mtval,
  output logic [XLEN-1:0]     mtval2,
  output logic [XLEN-1:0]     mtinst,
  output logic                s_sie,
  output logic                s_spie,
  output logic                s_spp,
  output logic                h_spv,
  output logic                h_spvp,
  output logic                h_gva,
  output logic [XLEN-1:0]     sepc,
  output logic [XLEN-1:0]     scause,
  output logic [XLEN-1:0]     stval,
  output logic [XLEN-1:0]     htval,
  output logic [XLEN-1:0]     htinst,
  output logic                vs_sie,
  output logic                vs_spie,
  output logic                vs_spp,
  output logic                vs_sdt,
  output logic [XLEN-1:0]     vsepc,
  output logic [XLEN-1:0]     vscause,
  output logic [XLEN-1:0]     vstval
);

  localparam int PADW = XLEN - 1 - CW;

  function automatic logic [XLEN-1:0] mk_cause(input logic irq, input logic [CW-1:0] c);
    return {irq, {PADW{1'b0}}, c};
  endfunction

  // Named events, visible to the assertions
  trap_dst_e       dst;
  logic            ev_trap;
  logic            ev_mret;
  logic            ev_sret;
  logic            ev_sret_hs;
  logic            ev_sret_vs;
  logic            ent_m;
  logic            ent_hs;
  logic            ent_vs;
  logic            vs_sdt_clr;
  logic [XLEN-1:0] cause_w;
  logic [1:0]      nxt_priv;
  logic            nxt_virt;
  logic [XLEN-1:0] nxt_pc;

  trap_route #(.CW(CW)) u_route (
    .irq     (trap_irq),
    .cause   (trap_cause),
    .prv     (priv),
    .virt    (virt),
    .medeleg (medeleg),
    .mideleg (mideleg),
    .hedeleg (hedeleg),
    .hideleg (hideleg),
    .dst     (dst)
  );

  assign cause_w    = mk_cause(trap_irq, trap_cause);
  assign ev_trap    = trap_req;
  assign ev_mret    = !trap_req && mret_req && (priv == PRV_M);
  assign ev_sret    = !trap_req && !ev_mret && sret_req && (priv != PRV_U);
  assign ev_sret_hs = ev_sret && !virt;
  assign ev_sret_vs = ev_sret && virt;
  assign ent_m      = ev_trap && (dst == DST_M);
  assign ent_hs     = ev_trap && (dst == DST_HS);
  assign ent_vs     = ev_trap && (dst == DST_VS);
  assign vs_sdt_clr = ev_sret_hs && h_spv && !s_spp;

  always_comb begin
    nxt_priv = priv;
    nxt_virt = virt;
    nxt_pc   = redir_pc;
    if (ent_m) begin
      nxt_priv = PRV_M;
      nxt_virt = 1'b0;
      nxt_pc   = m_tvec;
    end else if (ent_hs) begin
      nxt_priv = PRV_S;
      nxt_virt = 1'b0;
      nxt_pc   = s_tvec;
    end else if (ent_vs) begin
      nxt_priv = PRV_S;
      nxt_virt = 1'b1;
      nxt_pc   = vs_tvec;
    end else if (ev_mret) begin
      nxt_priv = m_mpp;
      nxt_virt = (m_mpp == PRV_M) ? 1'b0 : m_mpv;
      nxt_pc   = mepc;
    end else if (ev_sret_hs) begin
      nxt_priv = {1'b0, s_spp};
      nxt_virt = h_spv;
      nxt_pc   = sepc;
    end else if (ev_sret_vs) begin
      nxt_priv = {1'b0, vs_spp};
      nxt_virt = 1'b1;
      nxt_pc   = vsepc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      priv      <= PRV_M;
      virt      <= 1'b0;
      redir_vld <= 1'b0;
      redir_pc  <= '0;
    end else begin
      priv      <= nxt_priv;
      virt      <= nxt_virt;
      redir_vld <= ev_trap || ev_mret || ev_sret;
      redir_pc  <= nxt_pc;
    end
  end

  trap_mbank #(.XLEN(XLEN), .RST_MPP(RST_MPP), .RST_MPV(RST_MPV)) u_mbank (
    .clk      (clk),
    .rst_n    (rst_n),
    .ent      (ent_m),
    .ret      (ev_mret),
    .old_prv  (priv),
    .old_virt (virt),
    .gva      (trap_gva),
    .cause_w  (cause_w),
    .pc       (trap_pc),
    .tval     (trap_tval),
    .tval2    (trap_tval2),
    .tinst    (trap_tinst),
    .mie      (m_mie),
    .mpie     (m_mpie),
    .mpp      (m_mpp),
    .mpv      (m_mpv),
    .gva_q    (m_gva),
    .epc      (mepc),
    .cause_q  (mcause),
    .tval_q   (mtval),
    .tval2_q  (mtval2),
    .tinst_q  (mtinst)
  );

  trap_hsbank #(.XLEN(XLEN)) u_hsbank (
    .clk      (clk),
    .rst_n    (rst_n),
    .ent      (ent_hs),
    .ret      (ev_sret_hs),
    .old_s    (priv[0]),
    .old_virt (virt),
    .gva      (trap_gva),
    .cause_w  (cause_w),
    .pc       (trap_pc),
    .tval     (trap_tval),
    .tval2    (trap_tval2),
    .tinst    (trap_tinst),
    .sie      (s_sie),
    .spie     (s_spie),
    .spp      (s_spp),
    .spv      (h_spv),
    .spvp     (h_spvp),
    .gva_q    (h_gva),
    .epc      (sepc),
    .cause_q  (scause),
    .tval_q   (stval),
    .htval    (htval),
    .htinst   (htinst)
  );

  trap_vsbank #(.XLEN(XLEN), .DBL_TRAP(DBL_TRAP)) u_vsbank (
    .clk     (clk),
    .rst_n   (rst_n),
    .ent     (ent_vs),
    .ret     (ev_sret_vs),
    .clr     (vs_sdt_clr),
    .old_s   (priv[0]),
    .cause_w (cause_w),
    .pc      (trap_pc),
    .tval    (trap_tval),
    .sie     (vs_sie),
    .spie    (vs_spie),
    .spp     (vs_spp),
    .sdt     (vs_sdt),
    .epc     (vsepc),
    .cause_q (vscause),
    .tval_q  (vstval)
  );

  // R6: a VS-bound trap leaves every HS register and status bit alone
  a_r6_vs_keeps_hs: assert property (@(posedge clk) disable iff (!rst_n)
    ent_vs |=> $stable(sepc) && $stable(scause) && $stable(stval) && $stable(htval)
               && $stable(htinst) && $stable(s_sie) && $stable(s_spie) && $stable(s_spp)
               && $stable(h_spv) && $stable(h_spvp) && $stable(h_gva) && virt);

  // R2: a trap taken in M never leaves M
  a_r2_m_stays_m: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && priv == PRV_M) |=> (priv == PRV_M) && !virt);

  // R8: MRET with saved mode 3 returns to M with V cleared
  a_r8_mpp3_novirt: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_mret && m_mpp == PRV_M) |=> (priv == PRV_M) && !virt);

  // R13: MRET below M without other requests changes nothing
  a_r13_mret_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (mret_req && !trap_req && !sret_req && priv != PRV_M)
      |=> $stable(priv) && $stable(virt) && !redir_vld);

  // R12: no request, no redirect
  a_r12_no_redirect: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_req && !mret_req && !sret_req) |=> !redir_vld);

endmodule

// File: tb/sim_trap_seq.sv
`timescale 1ns/1ps
module sim_trap_seq;
  localparam int XLEN = 32;
  localparam int CW   = 5;
  localparam logic [31:0] MTV = 32'h0000_0100;
  localparam logic [31:0] STV = 32'h0000_0200;
  localparam logic [31:0] VTV = 32'h0000_0300;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, trap_req, trap_irq, trap_gva, mret_req, sret_req;
  logic [CW-1:0] trap_cause;
  logic [31:0] trap_pc, trap_tval, trap_tval2, trap_tinst;
  logic [31:0] medeleg, mideleg, hedeleg, hideleg;
  logic [1:0] priv, m_mpp;
  logic virt, redir_vld, m_mie, m_mpie, m_mpv, m_gva;
  logic s_sie, s_spie, s_spp, h_spv, h_spvp, h_gva, vs_sie, vs_spie, vs_spp, vs_sdt;
  logic [31:0] redir_pc, mepc, mcause, mtval, mtval2, mtinst;
  logic [31:0] sepc, scause, stval, htval, htinst, vsepc, vscause, vstval;

  trap_seq u0 (
    .clk(clk), .rst_n(rst_n), .trap_req(trap_req), .trap_irq(trap_irq),
    .trap_cause(trap_cause), .trap_pc(trap_pc), .trap_tval(trap_tval),
    .trap_tval2(trap_tval2), .trap_tinst(trap_tinst), .trap_gva(trap_gva),
    .mret_req(mret_req), .sret_req(sret_req), .medeleg(medeleg), .mideleg(mideleg),
    .hedeleg(hedeleg), .hideleg(hideleg), .m_tvec(MTV), .s_tvec(STV), .vs_tvec(VTV),
    .priv(priv), .virt(virt), .redir_vld(redir_vld), .redir_pc(redir_pc),
    .m_mie(m_mie), .m_mpie(m_mpie), .m_mpp(m_mpp), .m_mpv(m_mpv), .m_gva(m_gva),
    .mepc(mepc), .mcause(mcause), .mtval(mtval), .mtval2(mtval2), .mtinst(mtinst),
    .s_sie(s_sie), .s_spie(s_spie), .s_spp(s_spp), .h_spv(h_spv), .h_spvp(h_spvp),
    .h_gva(h_gva), .sepc(sepc), .scause(scause), .stval(stval), .htval(htval),
    .htinst(htinst), .vs_sie(vs_sie), .vs_spie(vs_spie), .vs_spp(vs_spp),
    .vs_sdt(vs_sdt), .vsepc(vsepc), .vscause(vscause), .vstval(vstval)
  );

  typedef struct {
    string       tag;
    logic [1:0]  prv;
    logic        v;
    logic        rv;
    logic [31:0] rpc;
    logic [15:0] st;
    logic [31:0] r [13];
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;

  // Bench-side reference state
  logic [1:0] b_prv, b_mpp;
  logic b_v, b_mie, b_mpie, b_mpv, b_mgva, b_sie, b_spie, b_spp, b_spv, b_spvp, b_hgva;
  logic b_vsie, b_vspie, b_vspp, b_sdt;
  logic [31:0] b_r [13]; // mepc mcause mtval mtval2 mtinst sepc scause stval htval htinst vsepc vscause vstval

  function automatic logic [15:0] st_of(input logic a0, a1, input logic [1:0] a2,
      input logic a3, a4, a5, a6, a7, a8, a9, a10, a11, a12, a13, a14);
    return {a0, a1, a2, a3, a4, a5, a6, a7, a8, a9, a10, a11, a12, a13, a14};
  endfunction

  task automatic chk(input string tag, input string nm, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, nm, act, exp);
    end
  endtask

  // Monitor: compares each expected item just after the edge that produces it
  always @(posedge clk) begin
    #2;
    if (q.size() > 0) begin
      exp_t e;
      logic [31:0] act [13];
      e = q.pop_front();
      act = '{mepc, mcause, mtval, mtval2, mtinst, sepc, scause, stval, htval, htinst,
              vsepc, vscause, vstval};
      chk(e.tag, "priv", {30'b0, priv}, {30'b0, e.prv});
      chk(e.tag, "virt", {31'b0, virt}, {31'b0, e.v});
      chk(e.tag, "redir_vld", {31'b0, redir_vld}, {31'b0, e.rv});
      if (e.rv) chk(e.tag, "redir_pc", redir_pc, e.rpc);
      chk(e.tag, "status", {16'b0, st_of(m_mie, m_mpie, m_mpp, m_mpv, m_gva, s_sie, s_spie,
          s_spp, h_spv, h_spvp, h_gva, vs_sie, vs_spie, vs_spp, vs_sdt)}, {16'b0, e.st});
      for (int i = 0; i < 13; i++) chk(e.tag, $sformatf("reg%0d", i), act[i], e.r[i]);
    end
  end

  // Driver: applies one request and pushes the expected state after it
  task automatic op(input string tag, input bit tr, input bit irq, input int c,
                    input logic [31:0] pc, input bit gva, input bit mr, input bit sr);
    exp_t e;
    logic [31:0] cw;
    int dst;
    @(negedge clk);
    trap_req = tr; trap_irq = irq; trap_cause = c[CW-1:0]; trap_pc = pc;
    trap_tval = pc ^ 32'h5A00_0000; trap_tval2 = pc >> 2; trap_tinst = pc + 32'h40;
    trap_gva = gva; mret_req = mr; sret_req = sr;
    e.rv = 1'b0; e.rpc = '0;
    cw = {irq, 26'b0, c[4:0]};
    if (tr) begin
      logic mb, hb;
      mb = irq ? mideleg[c] : medeleg[c];
      hb = irq ? hideleg[c] : hedeleg[c];
      if (b_prv == 2'd3 || !mb) dst = 0;
      else dst = (b_v && hb) ? 2 : 1;
      e.rv = 1'b1;
      case (dst)
        0: begin
          b_mpv = b_v; b_mpp = b_prv; b_mgva = gva; b_mpie = b_mie; b_mie = 1'b0;
          b_r[0] = pc; b_r[1] = cw; b_r[2] = trap_tval; b_r[3] = trap_tval2; b_r[4] = trap_tinst;
          b_prv = 2'd3; b_v = 1'b0; e.rpc = MTV;
        end
        1: begin
          if (b_v) b_spvp = b_prv[0];
          b_spv = b_v; b_hgva = gva; b_spp = b_prv[0]; b_spie = b_sie; b_sie = 1'b0;
          b_r[5] = pc; b_r[6] = cw; b_r[7] = trap_tval; b_r[8] = trap_tval2; b_r[9] = trap_tinst;
          b_prv = 2'd1; b_v = 1'b0; e.rpc = STV;
        end
        default: begin
          b_vspp = b_prv[0]; b_vspie = b_vsie; b_vsie = 1'b0; b_sdt = 1'b1;
          b_r[10] = pc; b_r[11] = cw; b_r[12] = trap_tval;
          b_prv = 2'd1; e.rpc = VTV;
        end
      endcase
    end else if (mr && b_prv == 2'd3) begin
      e.rv = 1'b1; e.rpc = b_r[0];
      b_v = (b_mpp == 2'd3) ? 1'b0 : b_mpv;
      b_prv = b_mpp; b_mpp = 2'd0; b_mpv = 1'b0; b_mie = b_mpie; b_mpie = 1'b1;
    end else if (sr && b_prv != 2'd0) begin
      e.rv = 1'b1;
      if (!b_v) begin
        e.rpc = b_r[5];
        if (b_spv && !b_spp) b_sdt = 1'b0;
        b_prv = {1'b0, b_spp}; b_v = b_spv;
        b_spv = 1'b0; b_sie = b_spie; b_spie = 1'b1; b_spp = 1'b0;
      end else begin
        e.rpc = b_r[10]; b_sdt = 1'b0;
        b_prv = {1'b0, b_vspp}; b_vsie = b_vspie; b_vspie = 1'b1; b_vspp = 1'b0;
      end
    end
    e.tag = tag; e.prv = b_prv; e.v = b_v;
    e.st = st_of(b_mie, b_mpie, b_mpp, b_mpv, b_mgva, b_sie, b_spie, b_spp, b_spv, b_spvp,
                 b_hgva, b_vsie, b_vspie, b_vspp, b_sdt);
    e.r = b_r;
    q.push_back(e);
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; trap_req = 0; trap_irq = 0; trap_cause = '0; trap_pc = '0;
    trap_tval = '0; trap_tval2 = '0; trap_tinst = '0; trap_gva = 0; mret_req = 0; sret_req = 0;
    medeleg = 32'h0000_1700; // codes 8, 9, 10, 12
    hedeleg = 32'h0000_0300; // codes 8, 9 (10 kept at HS)
    mideleg = 32'h0000_0022; // interrupts 1, 5
    hideleg = 32'h0000_0002; // interrupt 1
    b_prv = 2'd3; b_v = 0; b_mpp = 2'd1; b_mpv = 1; b_mie = 0; b_mpie = 0; b_mgva = 0;
    b_sie = 0; b_spie = 0; b_spp = 0; b_spv = 0; b_spvp = 0; b_hgva = 0;
    b_vsie = 0; b_vspie = 0; b_vspp = 0; b_sdt = 0;
    for (int i = 0; i < 13; i++) b_r[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    op("R1 reset",            0, 0, 0,  32'h0, 0, 0, 0);
    op("R8 R12 mret to VS",   0, 0, 0,  32'h0, 0, 1, 0);
    op("R2 R3 VS to M",       1, 0, 2,  32'h1000, 1, 0, 0);
    op("R8 mret to VS again", 0, 0, 0,  32'h0, 0, 1, 0);
    op("R4 R5 R7 ecall10 HS", 1, 0, 10, 32'h2000, 1, 0, 0);
    op("R9 sret to VS",       0, 0, 0,  32'h0, 0, 0, 1);
    op("R6 R7 R11 ecall9 VS", 1, 0, 9,  32'h3000, 0, 0, 0);
    op("R10 R11 sret in VS",  0, 0, 0,  32'h0, 0, 0, 1);
    op("R10 sret to VU",      0, 0, 0,  32'h0, 0, 0, 1);
    op("R13 sret in VU",      0, 0, 0,  32'h0, 0, 0, 1);
    op("R13 mret in VU",      0, 0, 0,  32'h0, 0, 1, 0);
    op("R6 R7 irq1 VU to VS", 1, 1, 1,  32'h4000, 0, 0, 0);
    op("R10 R11 sret to VU",  0, 0, 0,  32'h0, 0, 0, 1);
    op("R4 R5 irq5 VU to HS", 1, 1, 5,  32'h5000, 0, 0, 0);
    op("R5 R2 HS to HS",      1, 0, 8,  32'h6000, 1, 0, 0);
    op("R9 sret HS to HS",    0, 0, 0,  32'h0, 0, 0, 1);
    op("R9 sret HS to U",     0, 0, 0,  32'h0, 0, 0, 1);
    op("R13 sret in U",       0, 0, 0,  32'h0, 0, 0, 1);
    op("R2 U to HS",          1, 0, 12, 32'h7000, 0, 0, 0);
    op("R3 HS to M",          1, 0, 2,  32'h8000, 0, 0, 0);
    op("R2 M keeps deleg",    1, 0, 8,  32'h9000, 1, 0, 0);
    op("R8 mret mpp3",        0, 0, 0,  32'h0, 0, 1, 0);
    op("R13 trap beats mret", 1, 0, 2,  32'hA000, 0, 1, 0);
    op("R12 idle",            0, 0, 0,  32'h0, 0, 0, 0);
    @(negedge clk);
    trap_req = 0; mret_req = 0; sret_req = 0;
    repeat (3) @(posedge clk);
    #3;
    summary();
    $finish;
  end

endmodule